// File: doc/BRIEF.md
# UART FIFO DMA Ready Controller

This block holds the transmit and receive byte queues of a serial port together with the logic that tells an external DMA engine when to move data. The CPU side pushes bytes into the transmit queue and the transmit shifter pops them. The receiver pushes bytes into the receive queue and the CPU or the DMA engine pops them. Each queue keeps an occupancy count. A single control word turns the queues on or off, picks one of two DMA handshake policies and sets the receive trigger level. The same word can also flush the transmit queue. The flush bit clears itself.

Two active-low ready outputs drive the DMA engine. In the single-character policy, transmit-ready is low while the transmit queue is empty, and receive-ready is low while any byte is waiting. In the block-transfer policy, transmit-ready goes high only when the queue is completely full. Receive-ready goes low when the trigger level is reached or the receiver reports a time-out, and it then stays low until the receive queue drains. A receive interrupt marks the moment the receive count equals the trigger level.

Top module: `uart_dma_ready_ctrl`

## Requirements
- R1: After reset, the control readback is 0x00, both counts are 0, tx_rdy_n is 0, rx_rdy_n is 1, and rx_irq and all four error flags are 0.
- R2: With queues enabled (control bit 0 = 1), each queue holds 16 bytes and returns them in write order. With queues disabled, each queue holds one byte. Counts follow every accepted push and pop.
- R3: A push to a full queue and a pop from an empty queue leave the queue unchanged. Either one raises that queue's overflow or underflow flag for exactly one cycle, in the cycle after the request.
- R4: A control write stores the trigger code from bits [7:6], the DMA policy from bit 3 (0 = single-character, 1 = block-transfer) and the enable from bit 0. Bits 5, 4, 2 and 1 always read back as 0.
- R5: A control write with bit 2 set empties the transmit queue and zeroes its count at that clock edge. The receive queue is not affected.
- R6: A control write that changes bit 0 empties both queues at that clock edge.
- R7: The trigger code maps 0→1, 1→4, 2→8 and 3→14 bytes (1 byte when queues are disabled). rx_irq is high exactly while the receive count equals the trigger, and pushes continue to be accepted up to 16.
- R8: In the single-character policy, tx_rdy_n is 0 when the transmit queue is empty and 1 once it holds a byte.
- R9: In the single-character policy, rx_rdy_n is 0 while the receive queue holds at least one byte and 1 when it is empty.
- R10: In the block-transfer policy with queues enabled, tx_rdy_n is 1 only while the transmit queue holds 16 bytes.
- R11: In the block-transfer policy with queues enabled, rx_rdy_n falls when the receive count reaches the trigger. It stays 0 as the queue drains below the trigger and rises when the queue is empty.
- R12: In the block-transfer policy, an rx_timeout pulse with a non-empty receive queue drives rx_rdy_n low from the next cycle until the queue is empty. A pulse with an empty queue has no effect.
- R13: With queues disabled, the DMA policy bit has no effect and both ready outputs follow the single-character policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_data | input | 8 | Control word written |
| cfg_rdata | output | 8 | Control word readback |
| tx_push | input | 1 | Write a byte to the transmit queue |
| tx_data | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Transmit shifter takes the head byte |
| tx_head | output | 8 | Head byte of the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| tx_ovf | output | 1 | Transmit push rejected (one cycle) |
| tx_unf | output | 1 | Transmit pop rejected (one cycle) |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_data | input | 8 | Received byte |
| rx_pop | input | 1 | Read the head byte of the receive queue |
| rx_head | output | 8 | Head byte of the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_ovf | output | 1 | Receive push rejected (one cycle) |
| rx_unf | output | 1 | Receive pop rejected (one cycle) |
| rx_timeout | input | 1 | Receive time-out pulse |
| rx_irq | output | 1 | Receive count equals trigger |
| tx_rdy_n | output | 1 | Transmit DMA ready, active low |
| rx_rdy_n | output | 1 | Receive DMA ready, active low |

## Verification
Counts, control readback and the error flags are registered, so their new values appear in the cycle after the clock edge that takes a push, pop or control write. The ready outputs and rx_irq are combinational from the counts, so they change with the counts. The one exception is the time-out latch, which lowers rx_rdy_n one edge after the pulse. The head byte is combinational and is read while the pop is still asserted. Each bench task drives its inputs on a falling edge and samples on the next falling edge, which is exactly one rising edge later, so each result is read in the cycle it is due.

// File: rtl/uart_dma_pkg.sv
// Package: shared control-word layout and trigger decode for the UART DMA ready controller.
// Assumes the receive trigger table fits a 16-entry queue.
package uart_dma_pkg;

    typedef struct packed {
        logic [1:0] trig;  // receive trigger code
        logic       mode;  // 0 single-character, 1 block-transfer
        logic       en;    // queues enabled
    } ctrl_t;

    // Map a two-bit trigger code to a byte count.
    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Module: byte_fifo
// Circular byte queue with an occupancy count, a synchronous clear and a
// selectable one-entry capacity. It shows the head byte combinationally and
// raises one-cycle flags for a rejected push or pop.
// Assumes DEPTH is a power of two, so the pointers wrap by overflow.
module byte_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              cap_one,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              ovf,
    output logic              unf
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              full;
    logic              push_ok;
    logic              pop_ok;

    // Decide whether this cycle's requests can be accepted.
    always_comb begin
        full    = cap_one ? (count != '0) : (count == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && (count != '0);
    end

    // Pointer, count and error-flag state.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
            ovf <= push && full;
            unf <= pop && (count == '0);
        end
    end

    // Storage write; it needs no reset.
    always_ff @(posedge clk) begin
        if (push_ok && !clear) mem[wr_ptr] <= push_data;
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/fcr_reg.sv
// Module: fcr_reg
// Control word register. It stores the enable, the DMA policy and the trigger
// code. A set flush bit is turned into a same-edge transmit clear and is never
// stored, so it always reads back as 0. A change of the enable clears both queues.
module fcr_reg
    import uart_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_t      ctrl,
    output logic [7:0] rdata,
    output logic       tx_clear,
    output logic       rx_clear
);
    logic en_change;

    // Store the control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr) begin
            ctrl.trig <= wdata[7:6];
            ctrl.mode <= wdata[3];
            ctrl.en   <= wdata[0];
        end
    end

    // Derive the queue clears and the readback word.
    always_comb begin
        en_change = wr && (wdata[0] != ctrl.en);
        tx_clear  = (wr && wdata[2]) || en_change;
        rx_clear  = en_change;
        rdata     = {ctrl.trig, 2'b00, ctrl.mode, 2'b00, ctrl.en};
    end

endmodule

// File: rtl/ready_gen.sv
// Module: ready_gen
// Produces the active-low DMA ready outputs and the receive trigger interrupt
// from the queue counts. It keeps one latch that remembers, in the block-transfer
// policy, that the receive side was triggered (by level or time-out) until the
// queue is empty.
module ready_gen
    import uart_dma_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_timeout,
    output logic             tx_rdy_n,
    output logic             rx_rdy_n,
    output logic             rx_irq
);
    logic [CNT_W-1:0] trig_cnt;
    logic             blk_mode;
    logic             rx_empty;
    logic             at_trig;
    logic             armed;

    // Effective trigger and policy; a disabled queue behaves as single-character.
    always_comb begin
        trig_cnt = ctrl.en ? CNT_W'(trig_level(ctrl.trig)) : CNT_W'(1);
        blk_mode = ctrl.en && ctrl.mode;
        rx_empty = (rx_count == '0);
        at_trig  = (rx_count >= trig_cnt);
    end

    // Remember a block-transfer receive trigger until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_empty) armed <= 1'b0;
        else if (blk_mode && (at_trig || rx_timeout)) armed <= 1'b1;
    end

    // Drive the ready pins and the interrupt.
    always_comb begin
        if (blk_mode) begin
            tx_rdy_n = (tx_count != CNT_W'(DEPTH));
            tx_rdy_n = !tx_rdy_n;
            rx_rdy_n = rx_empty || !(armed || at_trig);
        end else begin
            tx_rdy_n = (tx_count != '0);
            rx_rdy_n = rx_empty;
        end
        rx_irq = (rx_count == trig_cnt);
    end

endmodule

// File: rtl/uart_dma_ready_ctrl.sv
// Module: uart_dma_ready_ctrl
// Top level: the control register, the transmit and receive byte queues, and the
// DMA ready and interrupt logic. The transmit shifter is modelled only as the pop port.
module uart_dma_ready_ctrl
    import uart_dma_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    output logic [7:0]        cfg_rdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_head,
    output logic [CNT_W-1:0]  tx_count,
    output logic              tx_ovf,
    output logic              tx_unf,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_head,
    output logic [CNT_W-1:0]  rx_count,
    output logic              rx_ovf,
    output logic              rx_unf,
    input  logic              rx_timeout,
    output logic              rx_irq,
    output logic              tx_rdy_n,
    output logic              rx_rdy_n
);
    ctrl_t ctrl;
    logic  tx_clear;
    logic  rx_clear;

    fcr_reg i_fcr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_data),
        .ctrl     (ctrl),
        .rdata    (cfg_rdata),
        .tx_clear (tx_clear),
        .rx_clear (rx_clear)
    );

    byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tx_clear),
        .cap_one   (!ctrl.en),
        .push      (tx_push),
        .push_data (tx_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .count     (tx_count),
        .ovf       (tx_ovf),
        .unf       (tx_unf)
    );

    byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (rx_clear),
        .cap_one   (!ctrl.en),
        .push      (rx_push),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .count     (rx_count),
        .ovf       (rx_ovf),
        .unf       (rx_unf)
    );

    ready_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .tx_count   (tx_count),
        .rx_count   (rx_count),
        .rx_timeout (rx_timeout),
        .tx_rdy_n   (tx_rdy_n),
        .rx_rdy_n   (rx_rdy_n),
        .rx_irq     (rx_irq)
    );

endmodule

// File: rtl/uart_dma_ready_ctrl_chk.sv
// Module: uart_dma_ready_ctrl_chk
// Port-level checker bound to the controller. It observes only the top-level ports.
module uart_dma_ready_ctrl_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [7:0]       cfg_data,
    input logic [7:0]       cfg_rdata,
    input logic             tx_push,
    input logic             rx_pop,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_ovf,
    input logic             rx_unf,
    input logic             rx_irq,
    input logic             tx_rdy_n,
    input logic             rx_rdy_n
);
    logic blk;
    assign blk = cfg_rdata[0] && cfg_rdata[3];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH))); // R2

    AST_TX_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |-> $past(tx_push) && (($past(tx_count) == CNT_W'(DEPTH)) ||
                   (!$past(cfg_rdata[0]) && $past(tx_count) == CNT_W'(1)))); // R3

    AST_RX_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_unf |-> $past(rx_pop) && ($past(rx_count) == '0)); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_data[2]) |=> (tx_count == '0)); // R5

    AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_count != '0)); // R7

    AST_TX_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk && tx_count == '0) |-> !tx_rdy_n); // R8

    AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> rx_rdy_n); // R9

    AST_RX_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && $past(blk) && !$past(rx_rdy_n) && rx_count != '0) |-> !rx_rdy_n); // R11

endmodule

bind uart_dma_ready_ctrl uart_dma_ready_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_data  (cfg_data),
    .cfg_rdata (cfg_rdata),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop),
    .tx_count  (tx_count),
    .rx_count  (rx_count),
    .tx_ovf    (tx_ovf),
    .rx_unf    (rx_unf),
    .rx_irq    (rx_irq),
    .tx_rdy_n  (tx_rdy_n),
    .rx_rdy_n  (rx_rdy_n)
);

// File: tb/test_uart_dma_ready_ctrl.sv
// Directed bench: one task per scenario. Inputs are driven on the falling edge
// and results are sampled on the next falling edge, one rising edge later.
module test_uart_dma_ready_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = '0;
    logic [7:0] cfg_rdata;
    logic       tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_pop = 1'b0;
    logic [7:0] tx_head;
    logic [4:0] tx_count;
    logic       tx_ovf, tx_unf;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_head;
    logic [4:0] rx_count;
    logic       rx_ovf, rx_unf;
    logic       rx_timeout = 1'b0;
    logic       rx_irq, tx_rdy_n, rx_rdy_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_dma_ready_ctrl i_uart_dma_ready_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .cfg_rdata(cfg_rdata),
        .tx_push(tx_push), .tx_data(tx_data), .tx_pop(tx_pop), .tx_head(tx_head),
        .tx_count(tx_count), .tx_ovf(tx_ovf), .tx_unf(tx_unf),
        .rx_push(rx_push), .rx_data(rx_data), .rx_pop(rx_pop), .rx_head(rx_head),
        .rx_count(rx_count), .rx_ovf(rx_ovf), .rx_unf(rx_unf),
        .rx_timeout(rx_timeout), .rx_irq(rx_irq), .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_data = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic txw(input logic [7:0] d);
        @(negedge clk); tx_push = 1'b1; tx_data = d;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic rxw(input logic [7:0] d);
        @(negedge clk); rx_push = 1'b1; rx_data = d;
        @(negedge clk); rx_push = 1'b0;
    endtask

    // Pop with the head byte checked while the pop is asserted.
    task automatic txr(input string req, input int exp);
        @(negedge clk); tx_pop = 1'b1;
        if (exp >= 0) chk(req, tx_head, exp);
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic rxr(input string req, input int exp);
        @(negedge clk); rx_pop = 1'b1;
        if (exp >= 0) chk(req, rx_head, exp);
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 cfg", cfg_rdata, 0);
        chk("R1 txcnt", tx_count, 0);
        chk("R1 rxcnt", rx_count, 0);
        chk("R1 txrdy", tx_rdy_n, 0);
        chk("R1 rxrdy", rx_rdy_n, 1);
        chk("R1 irq", rx_irq, 0);
        chk("R1 flags", {tx_ovf, tx_unf, rx_ovf, rx_unf}, 0);
    endtask

    task automatic t_disabled;
        txw(8'h5A);
        chk("R2 one-byte", tx_count, 1);
        chk("R8 txrdy high", tx_rdy_n, 1);
        txw(8'h77);
        chk("R3 tx ovf", tx_ovf, 1);
        chk("R3 count kept", tx_count, 1);
        @(negedge clk);
        chk("R3 ovf one cycle", tx_ovf, 0);
        txr("R3 data kept", 8'h5A);
        chk("R8 txrdy low", tx_rdy_n, 0);
        txr("R3", -1);
        chk("R3 tx unf", tx_unf, 1);
        rxw(8'h31);
        chk("R9 rxrdy low", rx_rdy_n, 0);
        chk("R7 irq trig1", rx_irq, 1);
        rxw(8'h32);
        chk("R3 rx ovf", rx_ovf, 1);
        cfg(8'h08);
        chk("R4 readback", cfg_rdata, 8'h08);
        chk("R13 rx kept", rx_count, 1);
        chk("R13 rxrdy", rx_rdy_n, 0);
        txw(8'h11);
        chk("R13 txrdy mode0", tx_rdy_n, 1);
    endtask

    task automatic t_enable_depth;
        cfg(8'hC1);
        chk("R6 tx cleared", tx_count, 0);
        chk("R6 rx cleared", rx_count, 0);
        chk("R4 readback", cfg_rdata, 8'hC1);
        for (int i = 0; i < 16; i++) txw(8'(i * 3 + 1));
        chk("R2 full", tx_count, 16);
        txw(8'hFF);
        chk("R3 full ovf", tx_ovf, 1);
        chk("R3 full count", tx_count, 16);
        for (int i = 0; i < 16; i++) txr("R2 order", (i * 3 + 1) & 8'hFF);
        chk("R2 drained", tx_count, 0);
    endtask

    task automatic t_flush;
        for (int i = 0; i < 5; i++) txw(8'(i));
        for (int i = 0; i < 3; i++) rxw(8'(i + 8'h40));
        cfg(8'hC5);
        chk("R4 flush bit reads 0", cfg_rdata, 8'hC1);
        chk("R5 tx flushed", tx_count, 0);
        chk("R5 rx kept", rx_count, 3);
        for (int i = 0; i < 3; i++) rxr("R5 rx data", i + 8'h40);
    endtask

    task automatic t_trigger;
        for (int k = 0; k < 4; k++) begin
            int trig;
            trig = (k == 0) ? 1 : (k == 1) ? 4 : (k == 2) ? 8 : 14;
            cfg(8'((k << 6) | 8'h09));
            for (int c = 1; c <= 16; c++) begin
                rxw(8'(c));
                chk("R7 irq", rx_irq, (c == trig) ? 1 : 0);
                chk("R11 rxrdy fill", rx_rdy_n, (c >= trig) ? 0 : 1);
            end
            chk("R7 accepts to full", rx_count, 16);
            for (int c = 15; c >= 0; c--) begin
                rxr("R7", -1);
                chk("R11 rxrdy drain", rx_rdy_n, (c == 0) ? 1 : 0);
            end
        end
    endtask

    task automatic t_block_tx;
        for (int i = 0; i < 15; i++) txw(8'(i));
        chk("R10 not full", tx_rdy_n, 0);
        txw(8'hEE);
        chk("R10 full", tx_rdy_n, 1);
        txr("R10", -1);
        chk("R10 one free", tx_rdy_n, 0);
        cfg(8'h0D);
        chk("R5 flush in mode1", tx_count, 0);
    endtask

    task automatic pulse_to;
        @(negedge clk); rx_timeout = 1'b1;
        @(negedge clk); rx_timeout = 1'b0;
    endtask

    task automatic t_timeout;
        cfg(8'hC9);
        pulse_to();
        chk("R12 empty ignored", rx_rdy_n, 1);
        rxw(8'h01);
        rxw(8'h02);
        chk("R12 below trig", rx_rdy_n, 1);
        pulse_to();
        chk("R12 timeout low", rx_rdy_n, 0);
        rxr("R12 data", 8'h01);
        chk("R12 stays low", rx_rdy_n, 0);
        rxr("R12 data", 8'h02);
        chk("R12 high on empty", rx_rdy_n, 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable_depth();
        t_flush();
        t_trigger();
        t_block_tx();
        t_timeout();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule